// File: doc/BRIEF.md
# Task Execution Time Monitor

This block watches a fixed set of software tasks for timing faults without taking any processor time. A scheduling kernel reports each task event on a small event port: start of a new invocation, preemption, resumption and completion. For every task the block keeps a cycle counter that advances only while that task runs. It compares the counter against two programmable limits: a lower bound, the best-case execution time, and an upper bound, the worst-case execution time.

A task that keeps running past its upper bound is reported as an overrun at once, while it is still running. A task that completes before its counter reaches the lower bound is reported as an underrun. A report raises an interrupt and carries the task number and the kind of bound that was broken. It stays latched until the kernel acknowledges it. Violations that occur while a report is pending are dropped, so the processor only ever sees one report at a time.

Limits are kept in several banks, one per operating mode, and are loaded through a plain address/data write port. A resynchronisation pulse selects the bank for the new mode and clears every counter and run flag, so stale counts cannot raise false alarms. Raising a quarantined task's lower bound to its old upper bound in another bank lets the kernel detect when that task is back to nominal timing.

Top module: `exec_time_monitor`

## Requirements
- R1: After reset the interrupt is low, the reported task is 0 and the reported kind is 0. Every lower bound resets to 0 and every upper bound to all ones, so no violation is possible before the bounds are written.
- R2: A start event clears that task's counter and marks it running. The counter then advances by one on every clock edge while the task is marked running, including the edge that takes a preempt or complete event. It holds while the task is preempted, so a run of a cycles, a preemption, and c cycles after resumption reaches a+1+c at completion.
- R3: If a running task's count exceeds its upper bound, an overrun with kind code 1 is raised while the task still runs. The interrupt rises on the edge after the count first exceeds the bound, and it is raised at most once per invocation. A task completing with a count equal to the upper bound raises nothing.
- R4: A complete event for a running task whose count is below its lower bound raises an underrun with kind code 0. A count equal to or above the lower bound raises nothing.
- R5: The interrupt, task number and kind stay unchanged until a one-cycle acknowledge; the interrupt is low on the edge after the acknowledge.
- R6: A violation occurring while a report is pending, including in the cycle of the acknowledge, is discarded and never reported.
- R7: When an overrun and an underrun arise in the same cycle, the overrun is reported.
- R8: A bound write stores the data at the address formed as {mode, task, select}: select in bit 0 (0 = lower bound, 1 = upper bound), the task number in the next bits, and the mode number in the top bits.
- R9: A resync pulse makes the given mode's bank active, and clears every counter and run flag. No violation is raised in the resync cycle, and a complete event for a task that is no longer running raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Kernel event strobe |
| ev_kind | input | 2 | Event code: 0 start, 1 preempt, 2 resume, 3 complete |
| ev_task | input | TID_W | Task the event refers to |
| sync_req | input | 1 | Resynchronise and switch bound bank |
| sync_mode | input | MODE_W | Mode whose bank becomes active on resync |
| cfg_we | input | 1 | Bound write enable |
| cfg_addr | input | AW | Bound address {mode, task, select} |
| cfg_data | input | CNT_W | Bound value |
| irq_ack | input | 1 | One-cycle acknowledge of the pending report |
| irq | output | 1 | Violation report pending |
| irq_task | output | TID_W | Task of the pending report |
| irq_kind | output | 1 | 0 underrun (lower bound), 1 overrun (upper bound) |

## Verification
The bench builds the block with its defaults: four tasks, two mode banks and 16-bit counters. The bounds it writes are small and differ for every task and bank. With these values it can sweep the run length of every task in both banks from zero to two past the upper bound, so each task crosses both edges of its legal window. The small bounds also let it place the exact rise of an overrun interrupt, and contrive a lower bound above the upper bound to force both violations into one cycle.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  typedef enum logic [1:0] {
    EV_START   = 2'd0,
    EV_PREEMPT = 2'd1,
    EV_RESUME  = 2'd2,
    EV_DONE    = 2'd3
  } ev_kind_e;

  localparam logic KIND_UNDER = 1'b0;
  localparam logic KIND_OVER  = 1'b1;
endpackage

// File: rtl/tmon_bound_bank.sv
module tmon_bound_bank #(
  parameter int NUM_TASKS = 4,
  parameter int NUM_MODES = 2,
  parameter int CNT_W     = 16,
  parameter int TID_W     = 2,
  parameter int MODE_W    = 1,
  parameter int AW        = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [AW-1:0]                    cfg_addr,
  input  logic [CNT_W-1:0]                 cfg_data,
  input  logic [MODE_W-1:0]                mode_q,
  output logic [NUM_TASKS-1:0][CNT_W-1:0]  act_lo,
  output logic [NUM_TASKS-1:0][CNT_W-1:0]  act_hi
);
  logic                 wr_sel;
  logic [TID_W-1:0]     wr_task;
  logic [MODE_W-1:0]    wr_mode;

  assign wr_sel  = cfg_addr[0];
  assign wr_task = cfg_addr[TID_W:1];
  assign wr_mode = cfg_addr[AW-1:TID_W+1];

  logic [CNT_W-1:0] lo_r [NUM_MODES][NUM_TASKS];
  logic [CNT_W-1:0] hi_r [NUM_MODES][NUM_TASKS];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
      logic hit;
      assign hit = cfg_we && (wr_mode == MODE_W'(m)) && (wr_task == TID_W'(t));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_r[m][t] <= '0;
          hi_r[m][t] <= '1;
        end else if (hit) begin
          if (wr_sel) hi_r[m][t] <= cfg_data;
          else        lo_r[m][t] <= cfg_data;
        end
      end
    end
  end

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_act
    assign act_lo[t] = lo_r[mode_q][t];
    assign act_hi[t] = hi_r[mode_q][t];
  end
endmodule

// File: rtl/tmon_task_timer.sv
module tmon_task_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             start,
  input  logic             resume,
  input  logic             pause,
  input  logic             finish,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  output logic             running,
  output logic             ovr_hit,
  output logic             und_hit
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  function automatic logic over_upper(input logic [CNT_W-1:0] v,
                                      input logic [CNT_W-1:0] lim);
    return v > lim;
  endfunction

  function automatic logic below_lower(input logic [CNT_W-1:0] v,
                                       input logic [CNT_W-1:0] lim);
    return v < lim;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             ovr_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (sync) begin
      run_q <= 1'b0;
    end else if (start || resume) begin
      run_q <= 1'b1;
    end else if (pause || finish) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sync || start) begin
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= sat_inc(cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_seen_q <= 1'b0;
    end else if (sync || start) begin
      ovr_seen_q <= 1'b0;
    end else if (ovr_hit) begin
      ovr_seen_q <= 1'b1;
    end
  end

  assign running = run_q;
  assign ovr_hit = !sync && run_q && !ovr_seen_q && over_upper(cnt_q, hi);
  assign und_hit = !sync && finish && run_q && below_lower(cnt_q, lo);

  // R2: count holds while the task is not running
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start && !sync) |=> $stable(cnt_q));

  // R2: a start clears the count and marks the task running
  a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sync) |=> (cnt_q == '0 && run_q));

  // R3: one overrun per invocation
  a_r3_overrun_once: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_hit && !start) |=> !ovr_hit);

  // R9: resync clears count and run flag
  a_r9_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (cnt_q == '0 && !run_q));
endmodule

// File: rtl/tmon_report.sv
module tmon_report #(
  parameter int NUM_TASKS = 4,
  parameter int TID_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TASKS-1:0] ovr_vec,
  input  logic [NUM_TASKS-1:0] und_vec,
  input  logic                 ack,
  output logic                 irq,
  output logic [TID_W-1:0]     irq_task,
  output logic                 irq_kind
);
  import tmon_pkg::*;

  function automatic logic [TID_W-1:0] first_set(input logic [NUM_TASKS-1:0] v);
    logic [TID_W-1:0] idx;
    idx = '0;
    for (int i = NUM_TASKS - 1; i >= 0; i--) begin
      if (v[i]) idx = TID_W'(i);
    end
    return idx;
  endfunction

  logic             any_viol;
  logic [TID_W-1:0] sel_task;
  logic             sel_kind;
  logic             accept;

  assign any_viol = (|ovr_vec) || (|und_vec);
  assign sel_kind = (|ovr_vec) ? KIND_OVER : KIND_UNDER;
  assign sel_task = (|ovr_vec) ? first_set(ovr_vec) : first_set(und_vec);
  assign accept   = any_viol && !irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      irq_task <= '0;
      irq_kind <= KIND_UNDER;
    end else if (irq) begin
      if (ack) irq <= 1'b0;
    end else if (accept) begin
      irq      <= 1'b1;
      irq_task <= sel_task;
      irq_kind <= sel_kind;
    end
  end

  // R5: report held until acknowledged
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> (irq && $stable(irq_task) && $stable(irq_kind)));

  // R5: acknowledge drops the interrupt
  a_r5_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack) |=> !irq);

  // R7: an overrun in the accepting cycle is reported as an overrun
  a_r7_over_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (|ovr_vec)) |=> (irq && irq_kind == KIND_OVER));
endmodule

// File: rtl/exec_time_monitor.sv
module exec_time_monitor #(
  parameter  int NUM_TASKS = 4,
  parameter  int NUM_MODES = 2,
  parameter  int CNT_W     = 16,
  localparam int TID_W     = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int MODE_W    = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
  localparam int AW        = MODE_W + TID_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [TID_W-1:0]  ev_task,
  input  logic              sync_req,
  input  logic [MODE_W-1:0] sync_mode,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CNT_W-1:0]  cfg_data,
  input  logic              irq_ack,
  output logic              irq,
  output logic [TID_W-1:0]  irq_task,
  output logic              irq_kind
);
  import tmon_pkg::*;

  logic [MODE_W-1:0]               mode_q;
  logic [NUM_TASKS-1:0][CNT_W-1:0] act_lo;
  logic [NUM_TASKS-1:0][CNT_W-1:0] act_hi;
  logic [NUM_TASKS-1:0]            run_vec;
  logic [NUM_TASKS-1:0]            ovr_vec;
  logic [NUM_TASKS-1:0]            und_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (sync_req && (int'(sync_mode) < NUM_MODES)) begin
      mode_q <= sync_mode;
    end
  end

  tmon_bound_bank #(
    .NUM_TASKS(NUM_TASKS), .NUM_MODES(NUM_MODES), .CNT_W(CNT_W),
    .TID_W(TID_W), .MODE_W(MODE_W), .AW(AW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .mode_q(mode_q), .act_lo(act_lo), .act_hi(act_hi)
  );

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_timer
    logic hit;
    logic ev_start, ev_pause, ev_resume, ev_finish;

    assign hit       = ev_valid && (ev_task == TID_W'(t));
    assign ev_start  = hit && (ev_kind == EV_START);
    assign ev_pause  = hit && (ev_kind == EV_PREEMPT);
    assign ev_resume = hit && (ev_kind == EV_RESUME);
    assign ev_finish = hit && (ev_kind == EV_DONE);

    tmon_task_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .sync(sync_req),
      .start(ev_start), .resume(ev_resume), .pause(ev_pause), .finish(ev_finish),
      .lo(act_lo[t]), .hi(act_hi[t]),
      .running(run_vec[t]), .ovr_hit(ovr_vec[t]), .und_hit(und_vec[t])
    );
  end

  tmon_report #(.NUM_TASKS(NUM_TASKS), .TID_W(TID_W)) u_report (
    .clk(clk), .rst_n(rst_n),
    .ovr_vec(ovr_vec), .und_vec(und_vec), .ack(irq_ack),
    .irq(irq), .irq_task(irq_task), .irq_kind(irq_kind)
  );

  // R2: a single processor runs at most one task at a time
  a_r2_single_runner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_vec));

  // R9: no report is accepted in a resync cycle
  a_r9_quiet_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && !irq) |=> !irq);
endmodule

// File: tb/test_exec_time_monitor.sv
module test_exec_time_monitor;
  import tmon_pkg::*;

  localparam int NT = 4;
  localparam int NM = 2;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0;
  logic [1:0]    ev_kind = 2'd0;
  logic [1:0]    ev_task = 2'd0;
  logic          sync_req = 1'b0;
  logic          sync_mode = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = 4'd0;
  logic [CW-1:0] cfg_data = '0;
  logic          irq_ack = 1'b0;
  logic          irq;
  logic [1:0]    irq_task;
  logic          irq_kind;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int lo_b [NM][NT];
  int hi_b [NM][NT];

  always #2 clk = ~clk;

  exec_time_monitor #(.NUM_TASKS(NT), .NUM_MODES(NM), .CNT_W(CW)) i_exec_time_monitor (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_task(ev_task),
    .sync_req(sync_req), .sync_mode(sync_mode), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .irq_ack(irq_ack), .irq(irq), .irq_task(irq_task), .irq_kind(irq_kind)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int m, input int t, input int sel, input int val);
    cfg_we = 1'b1;
    cfg_addr = 4'((m << 3) | (t << 1) | sel);
    cfg_data = CW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ev(input ev_kind_e k, input int t);
    ev_valid = 1'b1;
    ev_kind = k;
    ev_task = 2'(t);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_sync(input int m);
    sync_req = 1'b1;
    sync_mode = 1'(m);
    @(negedge clk);
    sync_req = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic run(input int t, input int n);
    ev(EV_START, t);
    repeat (n) @(negedge clk);
    ev(EV_DONE, t);
  endtask

  // expected report after a run of n cycles: 0 none, 1 underrun, 2 overrun
  function automatic int expect_code(input int n, input int lo, input int hi);
    if (n > hi) return 2;
    if (n < lo) return 1;
    return 0;
  endfunction

  task automatic check_report(input string req, input int code, input int t);
    chk(req, int'(irq), (code != 0) ? 1 : 0);
    if (code != 0) begin
      chk(req, int'(irq_task), t);
      chk(req, int'(irq_kind), (code == 2) ? 1 : 0);
      ack();
      chk({req, " R5 ack"}, int'(irq), 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and reset bounds
    chk("R1 irq", int'(irq), 0);
    chk("R1 task", int'(irq_task), 0);
    chk("R1 kind", int'(irq_kind), 0);
    run(0, 0);
    chk("R1 zero lower bound", int'(irq), 0);
    run(1, 60);
    chk("R1 max upper bound", int'(irq), 0);

    // R8: bank layout {mode, task, select}
    for (int m = 0; m < NM; m++) begin
      for (int t = 0; t < NT; t++) begin
        lo_b[m][t] = 3 + 2 * t + 4 * m;
        hi_b[m][t] = lo_b[m][t] + 3 + t;
        wr(m, t, 0, lo_b[m][t]);
        wr(m, t, 1, hi_b[m][t]);
      end
    end

    // R3 R4 R8 R9: sweep every task in both banks across both bounds
    for (int m = 0; m < NM; m++) begin
      do_sync(m);
      for (int t = 0; t < NT; t++) begin
        for (int n = 0; n <= hi_b[m][t] + 2; n++) begin
          run(t, n);
          check_report("R3/R4/R8 sweep", expect_code(n, lo_b[m][t], hi_b[m][t]), t);
          @(negedge clk);
        end
      end
    end
    do_sync(0);

    // R3: exact rise of the overrun interrupt while still running
    ev(EV_START, 0);
    repeat (hi_b[0][0] + 1) @(negedge clk);
    chk("R3 not yet", int'(irq), 0);
    @(negedge clk);
    chk("R3 rise", int'(irq), 1);
    chk("R3 kind", int'(irq_kind), 1);
    repeat (5) @(negedge clk);
    ev(EV_DONE, 0);
    check_report("R3 held", 2, 0);

    // R2: preempted run a, gap, resumed run c -> count a+1+c
    for (int a = 1; a <= 3; a++) begin
      ev(EV_START, 2);
      repeat (a) @(negedge clk);
      ev(EV_PREEMPT, 2);
      repeat (20) @(negedge clk);
      chk("R2 no count while preempted", int'(irq), 0);
      ev(EV_RESUME, 2);
      repeat (3) @(negedge clk);
      ev(EV_DONE, 2);
      check_report("R2 preempt total", expect_code(a + 1 + 3, lo_b[0][2], hi_b[0][2]), 2);
    end

    // R6: second violation dropped while first pending
    run(0, 0);
    run(1, 0);
    chk("R6 first kept", int'(irq_task), 0);
    chk("R6 kind", int'(irq_kind), 0);
    ack();
    chk("R6 second dropped", int'(irq), 0);
    // R6: violation in the acknowledge cycle is dropped
    run(3, 0);
    chk("R6 pending", int'(irq), 1);
    ev(EV_START, 0);
    irq_ack = 1'b1;
    ev(EV_DONE, 0);
    irq_ack = 1'b0;
    chk("R6 ack cycle drop", int'(irq), 0);

    // R7: overrun and underrun in the same cycle
    wr(0, 3, 0, 40);
    wr(0, 3, 1, 10);
    run(3, 11);
    chk("R7 reported", int'(irq), 1);
    chk("R7 overrun wins", int'(irq_kind), 1);
    ack();
    chk("R7 underrun not queued", int'(irq), 0);
    wr(0, 3, 0, lo_b[0][3]);
    wr(0, 3, 1, hi_b[0][3]);

    // R9: resync stops a running task and clears its count
    ev(EV_START, 1);
    repeat (3) @(negedge clk);
    do_sync(0);
    repeat (hi_b[0][1] + 10) @(negedge clk);
    chk("R9 no overrun after resync", int'(irq), 0);
    ev(EV_DONE, 1);
    chk("R9 no underrun after resync", int'(irq), 0);
    // R9: quarantine bank raises task 1 lower bound to its old upper bound
    wr(1, 1, 0, hi_b[0][1]);
    wr(1, 1, 1, 200);
    do_sync(1);
    run(1, hi_b[0][1] - 1);
    check_report("R9 quarantine underrun", 1, 1);
    run(1, hi_b[0][1]);
    check_report("R9 quarantine nominal", 0, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule